// File: doc/BRIEF.md
# I/O Subchannel Error Status Tracker

This block follows one I/O subchannel through a data transfer and keeps an eight-bit operational status byte for it. A successful start instruction puts the subchannel in the busy state. While it is busy, the block takes in single-cycle event pulses. These are the end of the channel, the exhaustion of the byte count, transfer faults, memory faults and command fetches. It latches each fault as a sticky bit. The bits stay set until the next successful start or halt instruction, or until reset.

Two command flags decide what a fault means. The first flag, suppress-length, turns a wrong-length transfer into a non-error. The second flag, halt-enable, lets the block stop the device when a transfer fault is found. When a halting fault occurs, the block emits a one-cycle halt request and leaves the busy state. A two-bit condition field reports one of four states: ready, not operational, engaged by another processor, or busy.

Top module: `iosc_status_tracker`

## Requirements
- R1: After reset, `status_o` is 8'h00, and `halt_req_o` and `error_o` are both 0.
- R2: `status_o[1:0]` shows the condition. It is 2'b01 while `ctl_fault_i` is high, which takes priority. Otherwise it is 2'b10 while `ctl_elsewhere_i` is high, 2'b11 while busy, and 2'b00 when ready. A `sio_i` pulse is successful only while the condition is 2'b00, and it makes the condition 2'b11 on the next cycle. Any other `sio_i` pulse is ignored.
- R3: While busy, a cycle with exactly one of `chan_end_i` and `count_done_i` sets the wrong-length bit `status_o[7]`. A cycle in which both arrive together does not set it.
- R4: While busy, `chan_end_i` ends the transfer, and the condition reads 2'b00 on the next cycle.
- R5: While busy, `parity_err_i` or `overrun_i` sets `status_o[6]`, and `data_mem_err_i` sets `status_o[5]`. These pulses are ignored when the subchannel is not busy.
- R6: While busy, `addr_err_i` sets `status_o[4]`. A `cmd_fetch_i` pulse with `cmd_mem_err_i` high sets `status_o[3]`.
- R7: While busy, a transfer-in-channel fetch (`cmd_fetch_i` with `cmd_is_tic_i` high) that directly follows another such fetch sets `status_o[2]`. Two things break the pair: a fetch that is not transfer-in-channel, or a successful start.
- R8: Bits 7 to 2 stay set until a successful start or halt clears them all. `hio_i` is successful only when neither `ctl_fault_i` nor `ctl_elsewhere_i` is high. An unsuccessful `sio_i` or `hio_i` changes nothing.
- R9: When a successful clear and a setting event arrive in the same cycle, the clear wins, and the bit reads 0 on the next cycle.
- R10: When `halt_en_i` is high, three events are halting faults: a wrong-length event with `supp_len_i` low, a data fault, or a memory fault. After a halting fault, `halt_req_o` is high for exactly one cycle, starting the next cycle, and the condition reads 2'b00 in that same cycle.
- R11: No halt is requested when `halt_en_i` is low. No halt is requested for a wrong-length event when `supp_len_i` is high. The bit is still set in both cases.
- R12: `error_o` is high when any of `status_o[6:2]` is set. It is also high when `status_o[7]` is set and `supp_len_i` is low.
- R13: A successful `hio_i` while busy returns the condition to 2'b00 on the next cycle. A halting fault in that same cycle raises no halt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sio_i | input | 1 | Start instruction strobe |
| hio_i | input | 1 | Halt instruction strobe |
| supp_len_i | input | 1 | Command flag: wrong length is not an error |
| halt_en_i | input | 1 | Command flag: halt device on transfer faults |
| ctl_fault_i | input | 1 | Controller not operational (level) |
| ctl_elsewhere_i | input | 1 | Controller engaged by another processor (level) |
| chan_end_i | input | 1 | Channel-end / end-of-record pulse |
| count_done_i | input | 1 | Byte count exhausted pulse |
| parity_err_i | input | 1 | Transfer parity fault pulse |
| overrun_i | input | 1 | Data overrun pulse |
| data_mem_err_i | input | 1 | Memory parity fault during data transfer |
| addr_err_i | input | 1 | Nonexistent address pulse |
| cmd_fetch_i | input | 1 | Command fetch pulse |
| cmd_is_tic_i | input | 1 | Fetched command is transfer-in-channel |
| cmd_mem_err_i | input | 1 | Memory parity fault on the fetch |
| status_o | output | 8 | Sticky fault bits [7:2], condition [1:0] |
| halt_req_o | output | 1 | One-cycle device halt request |
| error_o | output | 1 | Error indication |

## Verification
Two kinds of event can land in the same cycle. One is a successful halt instruction, which clears the sticky bits and leaves the busy state. The other is a fault pulse that would set a bit and might also request a halt. The bench drives a parity fault together with `hio_i` while the halt flag is low. It then drives a memory fault together with `hio_i` while the halt flag is high. In both cases the fault bit must read 0 on the next cycle, and in the second case no halt request may appear. A companion case drives `chan_end_i` and `count_done_i` together, which must be judged as a correct length.

// File: rtl/iosc_pkg.sv
package iosc_pkg;
    typedef enum logic [1:0] {
        COND_READY     = 2'b00,
        COND_NOTOP     = 2'b01,
        COND_ELSEWHERE = 2'b10,
        COND_BUSY      = 2'b11
    } cond_e;

    localparam int ERR_W   = 6;
    localparam int E_CTRL  = 0;
    localparam int E_FETCH = 1;
    localparam int E_ADDR  = 2;
    localparam int E_MEM   = 3;
    localparam int E_DATA  = 4;
    localparam int E_LEN   = 5;
endpackage

// File: rtl/iosc_len_check.sv
module iosc_len_check (
    input  logic active_i,
    input  logic chan_end_i,
    input  logic count_done_i,
    output logic mismatch_o,
    output logic done_o
);
    // wrong length: one of the two terminations arrived without the other
    always_comb begin
        mismatch_o = active_i & (chan_end_i ^ count_done_i);
        done_o     = active_i & chan_end_i;
    end
endmodule

// File: rtl/iosc_tic_seq.sv
module iosc_tic_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic fetch_i,
    input  logic is_tic_i,
    input  logic restart_i,
    output logic pair_o
);
    logic prev_d, prev_q;

    always_comb begin
        pair_o = active_i & fetch_i & is_tic_i & prev_q;
        prev_d = prev_q;
        if (active_i && fetch_i) prev_d = is_tic_i;
        if (restart_i)           prev_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    // R7: a non-TIC fetch always breaks the pair
    p_break_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && fetch_i && !is_tic_i) |=> !prev_q);
endmodule

// File: rtl/iosc_sticky_bank.sv
module iosc_sticky_bank #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] bits_o
);
    logic [W-1:0] bits_d, bits_q;

    for (genvar g = 0; g < W; g++) begin : g_bit
        always_comb begin
            if (clr_i) bits_d[g] = 1'b0;
            else       bits_d[g] = bits_q[g] | set_i[g];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign bits_o = bits_q;

    p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (bits_q == '0));

    p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((bits_q & $past(bits_q)) == $past(bits_q)));
endmodule

// File: rtl/iosc_status_tracker.sv
module iosc_status_tracker
    import iosc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sio_i,
    input  logic       hio_i,
    input  logic       supp_len_i,
    input  logic       halt_en_i,
    input  logic       ctl_fault_i,
    input  logic       ctl_elsewhere_i,
    input  logic       chan_end_i,
    input  logic       count_done_i,
    input  logic       parity_err_i,
    input  logic       overrun_i,
    input  logic       data_mem_err_i,
    input  logic       addr_err_i,
    input  logic       cmd_fetch_i,
    input  logic       cmd_is_tic_i,
    input  logic       cmd_mem_err_i,
    output logic [7:0] status_o,
    output logic       halt_req_o,
    output logic       error_o
);
    typedef struct packed {
        logic busy;
        logic halt;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    cond_e            cond;
    logic             sio_ok, hio_ok, clr;
    logic             len_evt, chan_done, pair_evt, hazard;
    logic [ERR_W-1:0] set_vec, err_q;

    iosc_len_check u_len (
        .active_i     (ctl_q.busy),
        .chan_end_i   (chan_end_i),
        .count_done_i (count_done_i),
        .mismatch_o   (len_evt),
        .done_o       (chan_done)
    );

    iosc_tic_seq u_tic (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (ctl_q.busy),
        .fetch_i   (cmd_fetch_i),
        .is_tic_i  (cmd_is_tic_i),
        .restart_i (sio_ok),
        .pair_o    (pair_evt)
    );

    iosc_sticky_bank #(.W(ERR_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .clr_i  (clr),
        .bits_o (err_q)
    );

    always_comb begin
        if (ctl_fault_i)          cond = COND_NOTOP;
        else if (ctl_elsewhere_i) cond = COND_ELSEWHERE;
        else if (ctl_q.busy)      cond = COND_BUSY;
        else                      cond = COND_READY;

        sio_ok = sio_i & (cond == COND_READY);
        hio_ok = hio_i & ~ctl_fault_i & ~ctl_elsewhere_i;
        clr    = sio_ok | hio_ok;

        set_vec          = '0;
        set_vec[E_LEN]   = len_evt;
        set_vec[E_DATA]  = ctl_q.busy & (parity_err_i | overrun_i);
        set_vec[E_MEM]   = ctl_q.busy & data_mem_err_i;
        set_vec[E_ADDR]  = ctl_q.busy & addr_err_i;
        set_vec[E_FETCH] = ctl_q.busy & cmd_fetch_i & cmd_mem_err_i;
        set_vec[E_CTRL]  = pair_evt;

        hazard = halt_en_i & ((len_evt & ~supp_len_i)
                              | set_vec[E_DATA] | set_vec[E_MEM]);

        ctl_d.halt = hazard & ~hio_ok;
        if (ctl_q.busy) ctl_d.busy = ~(chan_done | hio_ok | hazard);
        else            ctl_d.busy = sio_ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign status_o   = {err_q, cond};
    assign halt_req_o = ctl_q.halt;
    assign error_o    = (|err_q[E_DATA:E_CTRL]) | (err_q[E_LEN] & ~supp_len_i);

    p_sio_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sio_ok |=> ctl_q.busy);

    p_len_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (len_evt && !clr) |=> status_o[7]);

    p_ctrl_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_evt && !clr) |=> status_o[2]);

    p_halt_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req_o |=> !halt_req_o);

    p_halt_leaves_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req_o |-> !ctl_q.busy);

    p_hio_no_halt_r13: assert property (@(posedge clk) disable iff (!rst_n)
        hio_ok |=> (!halt_req_o && !ctl_q.busy));
endmodule

// File: tb/iosc_status_tracker_tb.sv
module iosc_status_tracker_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sio = 0, hio = 0, supp = 0, hen = 0, fault = 0, elsew = 0;
    logic cend = 0, cdone = 0, par = 0, ovr = 0, dmem = 0, addr = 0;
    logic fetch = 0, tic = 0, cmem = 0;
    logic [7:0] status;
    logic halt, err;
    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    iosc_status_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .sio_i(sio), .hio_i(hio),
        .supp_len_i(supp), .halt_en_i(hen), .ctl_fault_i(fault),
        .ctl_elsewhere_i(elsew), .chan_end_i(cend), .count_done_i(cdone),
        .parity_err_i(par), .overrun_i(ovr), .data_mem_err_i(dmem),
        .addr_err_i(addr), .cmd_fetch_i(fetch), .cmd_is_tic_i(tic),
        .cmd_mem_err_i(cmem), .status_o(status), .halt_req_o(halt),
        .error_o(err)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic start_op();
        sio = 1; cyc(); sio = 0;
    endtask

    task automatic halt_op();
        hio = 1; cyc(); hio = 0;
    endtask

    task automatic t_reset();
        chk("R1 status", status, 8'h00);
        chk("R1 halt", {7'd0, halt}, 8'h00);
        chk("R1 error", {7'd0, err}, 8'h00);
    endtask

    task automatic t_condition();
        fault = 1; #1 chk("R2 fault", status, 8'h01);
        elsew = 1; #1 chk("R2 fault priority", status, 8'h01);
        fault = 0; #1 chk("R2 elsewhere", status, 8'h02);
        sio = 1; cyc(); sio = 0;
        elsew = 0; #1 chk("R2 sio ignored", status, 8'h00);
        par = 1; cyc(); par = 0;
        chk("R5 ignored when idle", status, 8'h00);
        start_op();
        chk("R2 busy", status, 8'h03);
    endtask

    task automatic t_correct_len();
        hen = 1;
        cend = 1; cdone = 1; cyc(); cend = 0; cdone = 0;
        chk("R3 both together", status, 8'h00);
        chk("R10 no halt on correct length", {7'd0, halt}, 8'h00);
        hen = 0;
    endtask

    task automatic t_len_nohalt();
        start_op();
        cdone = 1; cyc(); cdone = 0;
        chk("R3 count first", status, 8'h83);
        chk("R12 error on length", {7'd0, err}, 8'h01);
        chk("R11 no halt, flag low", {7'd0, halt}, 8'h00);
        cend = 1; cyc(); cend = 0;
        chk("R4 end of transfer", status, 8'h80);
        supp = 1; #1 chk("R12 suppressed", {7'd0, err}, 8'h00);
        supp = 0; #1 chk("R12 unsuppressed", {7'd0, err}, 8'h01);
        halt_op();
        chk("R8 halt clears", status, 8'h00);
    endtask

    task automatic t_len_suppressed();
        supp = 1; hen = 1;
        start_op();
        cend = 1; cyc(); cend = 0;
        chk("R11 length bit kept", status, 8'h80);
        chk("R11 no halt when suppressed", {7'd0, halt}, 8'h00);
        chk("R12 no error when suppressed", {7'd0, err}, 8'h00);
        halt_op();
        supp = 0; hen = 0;
    endtask

    task automatic t_len_halt();
        hen = 1;
        start_op();
        cdone = 1; cyc(); cdone = 0;
        chk("R10 halt raised", {7'd0, halt}, 8'h01);
        chk("R10 ready with halt", status, 8'h80);
        cyc();
        chk("R10 halt one cycle", {7'd0, halt}, 8'h00);
        halt_op();
        start_op();
        par = 1; cyc(); par = 0;
        chk("R10 data fault halt", {7'd0, halt}, 8'h01);
        chk("R5 data bit", status, 8'h40);
        halt_op();
        hen = 0;
    endtask

    task automatic t_accumulate();
        start_op();
        ovr = 1; cyc(); ovr = 0;
        chk("R5 overrun", status, 8'h43);
        chk("R11 no halt, flag low", {7'd0, halt}, 8'h00);
        dmem = 1; cyc(); dmem = 0;
        chk("R5 memory bit", status, 8'h63);
        addr = 1; cyc(); addr = 0;
        chk("R6 address bit", status, 8'h73);
        fetch = 1; cmem = 1; cyc(); fetch = 0; cmem = 0;
        chk("R6 fetch memory bit", status, 8'h7b);
        sio = 1; cyc(); sio = 0;
        chk("R8 sio while busy ignored", status, 8'h7b);
        fault = 1; hio = 1; cyc(); hio = 0; fault = 0;
        #1 chk("R8 unsuccessful hio ignored", status, 8'h7b);
        halt_op();
        chk("R13 hio returns ready", status, 8'h00);
    endtask

    task automatic t_tic();
        start_op();
        fetch = 1; tic = 1; cyc();
        tic = 0; cyc();
        tic = 1; cyc(); fetch = 0; tic = 0;
        chk("R7 broken pair", status, 8'h03);
        fetch = 1; tic = 1; cyc(); fetch = 0; tic = 0;
        chk("R7 back-to-back", status, 8'h07);
        chk("R12 control error", {7'd0, err}, 8'h01);
        halt_op();
        start_op();
        fetch = 1; tic = 1; cyc(); fetch = 0; tic = 0;
        halt_op();
        start_op();
        fetch = 1; tic = 1; cyc(); fetch = 0; tic = 0;
        chk("R7 start breaks pair", status, 8'h03);
        halt_op();
    endtask

    task automatic t_same_cycle();
        start_op();
        par = 1; hio = 1; cyc(); par = 0; hio = 0;
        chk("R9 clear beats set", status, 8'h00);
        hen = 1;
        start_op();
        dmem = 1; hio = 1; cyc(); dmem = 0; hio = 0;
        chk("R9 clear beats memory fault", status, 8'h00);
        chk("R13 no halt with hio", {7'd0, halt}, 8'h00);
        hen = 0;
    endtask

    task automatic t_sticky_start();
        start_op();
        addr = 1; cyc(); addr = 0;
        cend = 1; cyc(); cend = 0;
        chk("R8 bit survives end", status, 8'h90);
        start_op();
        chk("R8 start clears", status, 8'h03);
        cend = 1; cdone = 1; cyc(); cend = 0; cdone = 0;
        chk("R4 ready again", status, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        t_reset();
        t_condition();
        t_correct_len();
        t_len_nohalt();
        t_len_suppressed();
        t_len_halt();
        t_accumulate();
        t_tic();
        t_same_cycle();
        t_sticky_start();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule